// File: doc/BRIEF.md
# Indexed Beat Capture Buffer

This block terminates a 128-bit valid/ready stream that carries an end-of-transfer marker. Every beat it accepts is written into the next free entry of an eight-entry capture store, so the first beat of a transfer lands in entry 0, the second in entry 1, and so on. The store is a linear capture area, not a FIFO. Once all entries hold data the block stops accepting beats, and only a reset frees it again.

Alongside the store the block keeps a running count of accepted beats and a sticky flag that rises once the marked final beat has been taken. It also keeps a full indication. A stall input lets surrounding logic withhold ready at any time. A separate random-access read port returns the contents of any entry by index, one cycle after the request, together with a valid strobe.

Fill progress is tracked by a small state machine with three states. `CAP_EMPTY` means nothing has been captured. `CAP_FILL` means at least one entry and fewer than all entries are written. `CAP_FULL` means every entry is written. The transitions are `CAP_EMPTY -> CAP_FILL` on the first accepted beat, `CAP_FILL -> CAP_FULL` on the beat that takes the last entry (and `CAP_EMPTY -> CAP_FULL` directly when the depth is one), and `CAP_FULL -> CAP_FULL` until reset.

Top module: `rxcap_buffer`

## Requirements
- R1: After reset, cap_count is 0, done_seen is 0, cap_full is 0, rd_valid is 0, and in_ready is 1 while cap_stall is low.
- R2: A beat is accepted when in_valid and in_ready are both 1 at a rising clock edge. It is stored in the entry whose index equals the number of beats accepted before it, so beat i is found at index i.
- R3: cap_count rises by exactly one in the cycle after each accepted beat and is otherwise unchanged.
- R4: While cap_stall is 1, in_ready is 0. A beat offered during a stall is neither stored nor counted.
- R5: cap_full rises in the cycle after the eighth accepted beat and stays 1 until reset. cap_count then reads 8.
- R6: While cap_full is 1, in_ready is 0. Further beats leave cap_count and every entry unchanged.
- R7: done_seen rises in the cycle after a beat with in_last = 1 is accepted and stays 1 until reset. Accepted beats with in_last = 0 do not set it.
- R8: Beats that follow the marked final beat are still accepted and stored while entries remain.
- R9: A read request (rd_en = 1 with index rd_idx) gives rd_valid = 1 and rd_data equal to that entry in the next cycle. rd_valid is 0 in any cycle that does not follow a request, and rd_data holds its last value then.
- R10: A read issued at the same edge as a write to the same entry returns the entry's contents from before that write.
- R11: An entry that has not been written since reset reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming beat is present |
| in_data | input | 128 | Incoming beat payload |
| in_last | input | 1 | Incoming beat is the final one of the transfer |
| in_ready | output | 1 | Block can take a beat this cycle |
| cap_stall | input | 1 | Forces in_ready low while 1 |
| rd_en | input | 1 | Read request strobe |
| rd_idx | input | 3 | Entry index to read |
| rd_data | output | 128 | Entry contents, registered |
| rd_valid | output | 1 | rd_data answers the previous cycle's request |
| cap_count | output | 4 | Number of beats accepted since reset |
| done_seen | output | 1 | Sticky: the marked final beat has been accepted |
| cap_full | output | 1 | Every entry holds a captured beat |

## Verification
The bench offers a beat while stall is high. A design that ignored stall would count that beat and fill entry 0. It also issues a read of entry 0 in the same cycle the first beat is written there; a store that bypassed the write would return the new beat instead of zeros. The end-of-transfer marker is placed mid-stream, on the fourth beat. This catches a flag that rises early, one that never latches, and a store that stops accepting after the marker. The bench then pushes a ninth beat into the full buffer, where a design without the full gate would wrap and overwrite entry 0 or let the count run past eight.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;

    typedef enum logic [1:0] {
        CAP_EMPTY = 2'd0,
        CAP_FILL  = 2'd1,
        CAP_FULL  = 2'd2
    } cap_state_e;

endpackage

// File: rtl/rxcap_fsm.sv
module rxcap_fsm
    import rxcap_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    output logic             full,
    output logic [IDX_W-1:0] wr_idx,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LAST_SLOT_CNT = CNT_W'(DEPTH - 1);

    cap_state_e state_q;
    cap_state_e state_d;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_EMPTY: begin
                if (accept) begin
                    state_d = (count_q == LAST_SLOT_CNT) ? CAP_FULL : CAP_FILL;
                end
            end
            CAP_FILL: begin
                if (accept && (count_q == LAST_SLOT_CNT)) begin
                    state_d = CAP_FULL;
                end
            end
            CAP_FULL: begin
                state_d = CAP_FULL;
            end
            default: begin
                state_d = CAP_EMPTY;
            end
        endcase
    end

    // beat counter, doubles as write pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (accept) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        full   = (state_q == CAP_FULL);
        wr_idx = count_q[IDX_W-1:0];
        count  = count_q;
    end

endmodule

// File: rtl/rxcap_slots.sv
module rxcap_slots #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 128,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    // one register per entry
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else if (wr_en && (int'(wr_idx) == s)) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    // registered read port: samples the contents from before this edge's write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= (int'(rd_idx) < DEPTH) ? slot_q[rd_idx] : '0;
            end
        end
    end

endmodule

// File: rtl/rxcap_buffer.sv
module rxcap_buffer #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              cap_stall,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  cap_count,
    output logic              done_seen,
    output logic              cap_full
);

    logic             accept;
    logic [IDX_W-1:0] wr_idx;
    logic             done_q;

    assign in_ready = !cap_full && !cap_stall;
    assign accept   = in_valid && in_ready;

    rxcap_fsm #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .full   (cap_full),
        .wr_idx (wr_idx),
        .count  (cap_count)
    );

    rxcap_slots #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) i_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_idx   (wr_idx),
        .wr_data  (in_data),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // sticky end-of-transfer flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (accept && in_last) begin
            done_q <= 1'b1;
        end
    end

    assign done_seen = done_q;

endmodule

// File: rtl/rxcap_buffer_chk.sv
module rxcap_buffer_chk #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_ready,
    input logic             cap_stall,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [CNT_W-1:0] cap_count,
    input logic             done_seen,
    input logic             cap_full
);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (cap_count == $past(cap_count) + CNT_W'(1)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(cap_count));

    // R4
    stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stall |-> !in_ready);

    // R5
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_full |=> cap_full);

    // R5
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_full |-> (cap_count == CNT_W'(DEPTH)));

    // R6
    full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_full |-> !in_ready);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |=> done_seen);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_seen) |-> $past(in_valid && in_ready && in_last));

    // R9
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R9
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

bind rxcap_buffer rxcap_buffer_chk #(.DEPTH(DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .cap_stall (cap_stall),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .cap_count (cap_count),
    .done_seen (done_seen),
    .cap_full  (cap_full)
);

// File: tb/test_rxcap_buffer.sv
`timescale 1ns/1ps
module test_rxcap_buffer;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_data;
    logic         in_last;
    logic         in_ready;
    logic         cap_stall;
    logic         rd_en;
    logic [2:0]   rd_idx;
    logic [127:0] rd_data;
    logic         rd_valid;
    logic [3:0]   cap_count;
    logic         done_seen;
    logic         cap_full;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rxcap_buffer i_rxcap_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .cap_stall (cap_stall),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .cap_count (cap_count),
        .done_seen (done_seen),
        .cap_full  (cap_full)
    );

    function automatic logic [127:0] pattern(input int n);
        return {32'hC0DE_0000 + 32'(n), 32'h1111_1111 * 32'(n + 1),
                ~(32'h0F0F_0000 + 32'(n)), 32'h8000_0000 | 32'(n)};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offer one beat for one cycle; sample at the following falling edge
    task automatic offer_beat(input logic [127:0] d, input logic lst);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = lst;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic read_slot(input int idx, input logic [127:0] exp, input string req);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_idx = 3'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, req, 128'(rd_valid), 128'd1);
        check(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(cap_count === 4'd0, "R1 count", 128'(cap_count), 128'd0);
        check(done_seen === 1'b0, "R1 done_seen", 128'(done_seen), 128'd0);
        check(cap_full === 1'b0, "R1 full", 128'(cap_full), 128'd0);
        check(rd_valid === 1'b0, "R1 rd_valid", 128'(rd_valid), 128'd0);
        check(in_ready === 1'b1, "R1 in_ready", 128'(in_ready), 128'd1);
    endtask

    task automatic t_stall();
        @(negedge clk);
        cap_stall = 1'b1;
        in_valid  = 1'b1;
        in_data   = pattern(77);
        in_last   = 1'b1;
        #1;
        check(in_ready === 1'b0, "R4 ready under stall", 128'(in_ready), 128'd0);
        @(negedge clk);
        check(cap_count === 4'd0, "R4 stalled beat not counted", 128'(cap_count), 128'd0);
        check(done_seen === 1'b0, "R4 stalled last ignored", 128'(done_seen), 128'd0);
        in_valid  = 1'b0;
        in_last   = 1'b0;
        cap_stall = 1'b0;
        read_slot(0, 128'd0, "R4 R11 entry 0 untouched");
        @(negedge clk);
        check(rd_valid === 1'b0, "R9 valid drops", 128'(rd_valid), 128'd0);
    endtask

    task automatic t_read_during_write();
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = pattern(0);
        in_last  = 1'b0;
        rd_en    = 1'b1;
        rd_idx   = 3'd0;
        @(negedge clk);
        in_valid = 1'b0;
        rd_en    = 1'b0;
        check(rd_valid === 1'b1, "R10 valid", 128'(rd_valid), 128'd1);
        check(rd_data === 128'd0, "R10 old contents", rd_data, 128'd0);
        check(cap_count === 4'd1, "R3 count after first", 128'(cap_count), 128'd1);
        read_slot(0, pattern(0), "R2 R9 entry 0");
    endtask

    task automatic t_fill_and_overflow();
        for (int i = 1; i < 8; i++) begin
            offer_beat(pattern(i), (i == 3));
            check(cap_count === 4'(i + 1), "R3 R8 count", 128'(cap_count), 128'(i + 1));
            if (i < 3)
                check(done_seen === 1'b0, "R7 no early done", 128'(done_seen), 128'd0);
            else
                check(done_seen === 1'b1, "R7 done sticky", 128'(done_seen), 128'd1);
            if (i < 7)
                check(cap_full === 1'b0, "R5 not yet full", 128'(cap_full), 128'd0);
        end
        check(cap_full === 1'b1, "R5 full after eighth", 128'(cap_full), 128'd1);
        check(in_ready === 1'b0, "R6 ready low when full", 128'(in_ready), 128'd0);
        offer_beat(pattern(99), 1'b0);
        check(cap_count === 4'd8, "R6 count held", 128'(cap_count), 128'd8);
        check(cap_full === 1'b1, "R5 full held", 128'(cap_full), 128'd1);
        for (int i = 0; i < 8; i++) begin
            read_slot(i, pattern(i), "R2 R6 R8 entry order");
        end
        @(negedge clk);
        check(rd_valid === 1'b0, "R9 idle valid", 128'(rd_valid), 128'd0);
        check(rd_data === pattern(7), "R9 data held", rd_data, pattern(7));
    endtask

    task automatic t_reset_clears();
        do_reset();
        check(cap_count === 4'd0, "R1 count cleared", 128'(cap_count), 128'd0);
        check(done_seen === 1'b0, "R1 R7 done cleared", 128'(done_seen), 128'd0);
        check(cap_full === 1'b0, "R1 R5 full cleared", 128'(cap_full), 128'd0);
        read_slot(2, 128'd0, "R11 entry 2 zero");
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        in_last = 1'b0;
        cap_stall = 1'b0;
        rd_en = 1'b0;
        rd_idx = '0;
        t_reset_state();
        t_stall();
        t_read_during_write();
        t_fill_and_overflow();
        t_reset_clears();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule